// File: doc/BRIEF.md
# Stereo Linear Attenuator with Soft Mute

The block scales a stream of signed stereo samples by a per-channel gain of `code / 2^CODE_W`, where the code is an unsigned `CODE_W`-bit value (8 bits by default, so the gain is `code/256`). Each input sample qualified by `in_valid` produces one scaled left/right pair, registered, one clock later with `out_valid`.

Gain codes are written into a staging buffer per channel. A write does not touch the gain in use unless its load flag is set. A pending load moves both staged codes into the active gains together, at one sample boundary, so a stereo balance change never shows up on one side before the other. A link input makes the left active code drive both channels. A soft-mute input walks the gain down one code step per sample to zero. When mute is released, the gain walks back up to the active code.

Top module: `stereo_atten`

## Requirements
- R1: After reset `out_valid`, `out_left` and `out_right` are 0, and both active codes equal `DEFAULT_CODE` (255), so a sample `s` comes out as `(s*255)>>>8`.
- R2: For every cycle with `in_valid` high, the next cycle has `out_valid` high and each output equals `(sample * gain) >>> CODE_W`, using arithmetic shift and a signed sample.
- R3: A code write with its load flag low leaves the gain of every later sample unchanged.
- R4: A write with its load flag high arms a load. The first `in_valid` cycle after the write cycle still uses the old codes, and every later sample uses both staged codes. A load armed in a sample cycle waits for the next sample cycle.
- R5: While `link_en` is high, the right channel uses the left active code. The right active code still governs once `link_en` is low.
- R6: While `mute_en` is high, each sample uses a gain one lower than the sample before it, until the gain reaches 0. It then stays at 0. The first muted sample uses the gain the channel had.
- R7: After `mute_en` falls, each sample's gain is one higher than the last, starting from the muted gain, until the next step would reach the active code. From then on the active code applies.
- R8: A gain of 0 gives an output of exactly 0, for any sample including the most negative one.
- R9: In a cycle after one with `in_valid` low, `out_valid` is low and both outputs keep their values.
- R10: A load during mute does not disturb the downward ramp. The release then ramps toward the newly loaded codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample pair is valid |
| in_left | input | SAMPLE_W | Left sample, signed |
| in_right | input | SAMPLE_W | Right sample, signed |
| left_wr | input | 1 | Write `left_code` into the left staging buffer |
| left_code | input | CODE_W | Left gain code |
| left_load | input | 1 | With `left_wr`: arm a load of both staged codes |
| right_wr | input | 1 | Write `right_code` into the right staging buffer |
| right_code | input | CODE_W | Right gain code |
| right_load | input | 1 | With `right_wr`: arm a load of both staged codes |
| link_en | input | 1 | Left active code drives both channels |
| mute_en | input | 1 | Soft mute request |
| out_valid | output | 1 | Output pair is valid |
| out_left | output | SAMPLE_W | Scaled left sample |
| out_right | output | SAMPLE_W | Scaled right sample |

## Verification
Two events can land in the same sample cycle: a gain code load and the step of the mute ramp (or the plain scaling of that sample). The bench provokes this by writing a code with its load flag in the same cycle as a sample, and by loading new codes while mute is ramping down. A scoreboard model predicts each sample's gain from the requirements alone. It then judges that the sample in the load cycle still uses the old code, that the ramp continues untouched by the load, and that the release climbs toward the codes loaded mid-mute.

// File: rtl/stereo_atten_pkg.sv
package stereo_atten_pkg;
   localparam int unsigned NCH   = 2;
   localparam int unsigned CH_L  = 0;
   localparam int unsigned CH_R  = 1;
endpackage

// File: rtl/atten_code_stage.sv
module atten_code_stage
   import stereo_atten_pkg::*;
#(
   parameter int unsigned CODE_W       = 8,
   parameter int unsigned DEFAULT_CODE = 255
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          smp,
   input  logic [NCH-1:0]                wr_en,
   input  logic [NCH-1:0][CODE_W-1:0]    wr_code,
   input  logic [NCH-1:0]                wr_load,
   output logic [NCH-1:0][CODE_W-1:0]    act_code
);
   localparam logic [CODE_W-1:0] DEF = CODE_W'(DEFAULT_CODE);

   logic [NCH-1:0][CODE_W-1:0] pend;
   logic                       arm_q;
   logic                       arm_new;

   assign arm_new = |(wr_en & wr_load);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
      end else if (smp && arm_q) begin
         arm_q <= arm_new;
      end else begin
         arm_q <= arm_q | arm_new;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend[c]     <= DEF;
            act_code[c] <= DEF;
         end else begin
            if (smp && arm_q) act_code[c] <= pend[c];
            if (wr_en[c])     pend[c]     <= wr_code[c];
         end
      end
   end

   p_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(smp && arm_q) |=> $stable(act_code));

   p_load_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp && arm_q) |=> act_code == $past(pend));
endmodule

// File: rtl/atten_gain_ramp.sv
module atten_gain_ramp #(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              mute,
   input  logic [CODE_W-1:0] target,
   output logic [CODE_W-1:0] gain
);
   logic [CODE_W-1:0] eff;
   logic              trk;
   logic [CODE_W:0]   eff_inc;

   assign eff_inc = {1'b0, eff} + (CODE_W+1)'(1);
   assign gain    = trk ? target : eff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         eff <= '0;
         trk <= 1'b1;
      end else if (step) begin
         if (mute) begin
            eff <= (gain == '0) ? '0 : gain - 1'b1;
            trk <= 1'b0;
         end else if (!trk) begin
            if (eff_inc >= {1'b0, target}) trk <= 1'b1;
            else                           eff <= eff_inc[CODE_W-1:0];
         end
      end
   end

   p_mute_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && mute && gain != '0) |=> (!trk && eff == $past(gain) - 1'b1));

   p_mute_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && mute && gain == '0) |=> (!trk && eff == '0));

   p_release_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !mute && !trk && eff_inc < {1'b0, target}) |=> eff == $past(eff) + 1'b1);

   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(eff) && $stable(trk)));
endmodule

// File: rtl/atten_scaler.sv
module atten_scaler #(
   parameter int unsigned SAMPLE_W = 24,
   parameter int unsigned CODE_W   = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       en,
   input  logic signed [SAMPLE_W-1:0] x,
   input  logic [CODE_W-1:0]          g,
   output logic signed [SAMPLE_W-1:0] y
);
   localparam int unsigned PW = SAMPLE_W + CODE_W + 1;

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] shifted;

   assign prod    = x * $signed({1'b0, g});
   assign shifted = prod >>> CODE_W;

   always_ff @(posedge clk) begin
      if (!rst_n)  y <= '0;
      else if (en) y <= shifted[SAMPLE_W-1:0];
   end

   p_zero_gain_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && g == '0) |=> y == '0);

   p_hold_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(y));
endmodule

// File: rtl/stereo_atten.sv
module stereo_atten
   import stereo_atten_pkg::*;
#(
   parameter int unsigned SAMPLE_W     = 24,
   parameter int unsigned CODE_W       = 8,
   parameter int unsigned DEFAULT_CODE = 255
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_left,
   input  logic [SAMPLE_W-1:0] in_right,
   input  logic                left_wr,
   input  logic [CODE_W-1:0]   left_code,
   input  logic                left_load,
   input  logic                right_wr,
   input  logic [CODE_W-1:0]   right_code,
   input  logic                right_load,
   input  logic                link_en,
   input  logic                mute_en,
   output logic                out_valid,
   output logic [SAMPLE_W-1:0] out_left,
   output logic [SAMPLE_W-1:0] out_right
);
   if (SAMPLE_W < 2 || SAMPLE_W > 32) begin : g_bad_sample_w
      $error("stereo_atten: SAMPLE_W out of range");
   end
   if (CODE_W < 1 || CODE_W > 16) begin : g_bad_code_w
      $error("stereo_atten: CODE_W out of range");
   end
   if (DEFAULT_CODE >= (1 << CODE_W)) begin : g_bad_default
      $error("stereo_atten: DEFAULT_CODE does not fit CODE_W");
   end

   logic [NCH-1:0]                       wr_en, wr_load;
   logic [NCH-1:0][CODE_W-1:0]           wr_code, act_code, target, gain;
   logic [NCH-1:0][SAMPLE_W-1:0]         smp_in, smp_out;

   assign wr_en[CH_L]   = left_wr;
   assign wr_en[CH_R]   = right_wr;
   assign wr_load[CH_L] = left_load;
   assign wr_load[CH_R] = right_load;
   assign wr_code[CH_L] = left_code;
   assign wr_code[CH_R] = right_code;
   assign smp_in[CH_L]  = in_left;
   assign smp_in[CH_R]  = in_right;

   atten_code_stage #(.CODE_W(CODE_W), .DEFAULT_CODE(DEFAULT_CODE)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp      (in_valid),
      .wr_en    (wr_en),
      .wr_code  (wr_code),
      .wr_load  (wr_load),
      .act_code (act_code)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      if (c == CH_L) begin : g_master
         assign target[c] = act_code[c];
      end else begin : g_follow
         assign target[c] = link_en ? act_code[CH_L] : act_code[c];
      end

      atten_gain_ramp #(.CODE_W(CODE_W)) u_ramp (
         .clk    (clk),
         .rst_n  (rst_n),
         .step   (in_valid),
         .mute   (mute_en),
         .target (target[c]),
         .gain   (gain[c])
      );

      atten_scaler #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W)) u_scale (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (in_valid),
         .x     (smp_in[c]),
         .g     (gain[c]),
         .y     (smp_out[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   assign out_left  = smp_out[CH_L];
   assign out_right = smp_out[CH_R];

   p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_no_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_link_gain_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (link_en && !mute_en && in_valid && gain[CH_L] == act_code[CH_L]
       && gain[CH_R] == target[CH_R]) |-> gain[CH_R] == gain[CH_L]);
endmodule

// File: tb/stereo_atten_tb_top.sv
module stereo_atten_tb_top;
   localparam int SW = 24;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [SW-1:0] in_left = '0, in_right = '0;
   logic          left_wr = 1'b0, left_load = 1'b0, right_wr = 1'b0, right_load = 1'b0;
   logic [CW-1:0] left_code = '0, right_code = '0;
   logic          link_en = 1'b0, mute_en = 1'b0;
   logic          out_valid;
   logic [SW-1:0] out_left, out_right;

   always #2.5 clk = ~clk;

   stereo_atten #(.SAMPLE_W(SW), .CODE_W(CW), .DEFAULT_CODE(255)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_left(in_left), .in_right(in_right),
      .left_wr(left_wr), .left_code(left_code), .left_load(left_load),
      .right_wr(right_wr), .right_code(right_code), .right_load(right_load),
      .link_en(link_en), .mute_en(mute_en),
      .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [SW-1:0] q_l[$];
   logic [SW-1:0] q_r[$];
   string         q_tag[$];

   int  m_act[2], m_pend[2], m_eff[2];
   bit  m_trk[2];
   bit  m_arm;
   bit  g_mute = 1'b0, g_link = 1'b0;
   logic sent_q = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] scale(input int s, input int g);
      longint p;
      p = longint'(s) * longint'(g);
      return SW'(p >>> CW);
   endfunction

   task automatic model_reset();
      for (int c = 0; c < 2; c++) begin
         m_act[c] = 255; m_pend[c] = 255; m_eff[c] = 0; m_trk[c] = 1'b1;
      end
      m_arm = 1'b0;
   endtask

   task automatic tick(input bit v, input int sl, input int sr,
                       input bit wl, input int cl, input bit ll,
                       input bit wr, input int cr, input bit lr, input string tag);
      int sel[2];
      int g[2];
      bit anyload;
      @(negedge clk);
      in_valid = v; in_left = SW'(sl); in_right = SW'(sr);
      left_wr = wl; left_code = CW'(cl); left_load = ll;
      right_wr = wr; right_code = CW'(cr); right_load = lr;
      mute_en = g_mute; link_en = g_link;
      sel[0] = m_act[0];
      sel[1] = g_link ? m_act[0] : m_act[1];
      for (int c = 0; c < 2; c++) g[c] = m_trk[c] ? sel[c] : m_eff[c];
      if (v) begin
         q_l.push_back(scale(sl, g[0]));
         q_r.push_back(scale(sr, g[1]));
         q_tag.push_back(tag);
         for (int c = 0; c < 2; c++) begin
            if (g_mute) begin
               m_eff[c] = (g[c] > 0) ? g[c] - 1 : 0;
               m_trk[c] = 1'b0;
            end else if (!m_trk[c]) begin
               if (m_eff[c] + 1 >= sel[c]) m_trk[c] = 1'b1;
               else                        m_eff[c] = m_eff[c] + 1;
            end
         end
         if (m_arm) begin
            m_act[0] = m_pend[0]; m_act[1] = m_pend[1];
         end
      end
      anyload = (wl && ll) || (wr && lr);
      if (wl) m_pend[0] = cl;
      if (wr) m_pend[1] = cr;
      if (v && m_arm) m_arm = anyload;
      else            m_arm = m_arm | anyload;
   endtask

   task automatic smp(input int sl, input int sr, input string tag);
      tick(1'b1, sl, sr, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0, tag);
   endtask

   task automatic idle();
      tick(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0, "R9");
   endtask

   task automatic load_both(input int cl, input int cr);
      tick(1'b0, 0, 0, 1'b1, cl, 1'b0, 1'b1, cr, 1'b1, "R4");
   endtask

   always @(posedge clk) sent_q <= rst_n ? in_valid : 1'b0;

   // monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(out_valid === sent_q, "R9", "out_valid", longint'(out_valid), longint'(sent_q));
         if (out_valid === 1'b1) begin
            if (q_l.size() == 0) begin
               check(1'b0, "R2", "unexpected output", 1, 0);
            end else begin
               logic [SW-1:0] el, er;
               string t;
               el = q_l.pop_front(); er = q_r.pop_front(); t = q_tag.pop_front();
               check(out_left === el, t, "out_left",
                     longint'($signed(out_left)), longint'($signed(el)));
               check(out_right === er, t, "out_right",
                     longint'($signed(out_right)), longint'($signed(er)));
            end
         end
      end
   end

   initial begin
      #(5ns * 50000);
      if (!finished) begin
         finished = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(out_valid === 1'b0, "R1", "reset out_valid", longint'(out_valid), 0);
      check(out_left === '0 && out_right === '0, "R1", "reset outputs",
            longint'(out_left), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0, "R1", "post-reset out_valid", longint'(out_valid), 0);

      // R1 default code, R2 scaling
      smp(1000, -1000, "R1");
      smp(8388607, -8388608, "R1");
      smp(-1, 256, "R2");
      idle(); idle();

      // R3 writes without load
      tick(1'b0, 0, 0, 1'b1, 128, 1'b0, 1'b0, 0, 1'b0, "R3");
      tick(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 64, 1'b0, "R3");
      smp(5000, 5000, "R3");
      smp(-5000, -3, "R3");

      // R4 load arms, applies after first sample
      tick(1'b0, 0, 0, 1'b0, 0, 1'b0, 1'b1, 64, 1'b1, "R4");
      smp(4096, 4096, "R4");
      smp(4096, 4096, "R4");
      smp(-7, 7, "R2");
      smp(12345, -54321, "R2");

      // R4 load in the same cycle as a sample
      tick(1'b1, 3000, 3000, 1'b1, 200, 1'b1, 1'b0, 0, 1'b0, "R4");
      smp(3000, 3000, "R4");
      smp(3000, 3000, "R4");

      // R5 link
      g_link = 1'b1;
      smp(10000, 10000, "R5");
      smp(-777, 20000, "R5");
      g_link = 1'b0;
      smp(10000, 10000, "R5");

      // R8 zero code, R2 small code
      load_both(0, 1);
      smp(-8388608, -1, "R8");
      smp(-8388608, -1, "R8");
      smp(8388607, 300, "R8");

      // R6 mute ramp down with gaps
      load_both(10, 6);
      smp(100000, 100000, "R6");
      g_mute = 1'b1;
      for (int i = 0; i < 8; i++) begin
         smp(100000, -100000, "R6");
         if (i % 3 == 1) idle();
      end
      // R10 load during mute
      load_both(20, 3);
      for (int i = 0; i < 6; i++) smp(100000, -100000, "R10");

      // R7 release to new codes
      g_mute = 1'b0;
      for (int i = 0; i < 25; i++) begin
         smp(65536, -65536, "R7");
         if (i == 4) idle();
      end
      idle(); idle();

      finished = 1'b1;
      check(q_l.size() == 0, "R2", "pending results", q_l.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule